// File: doc/BRIEF.md
# Manchester Data Clock Recovery

This block recovers a data stream and a data-clock strobe from a demodulated, self-clocked serial line. The line is sampled by the system clock and passed through a synchronizer. The spacing between successive transitions is then counted in clock cycles, and each spacing is sorted into a short (one half-bit, T) or a long (two half-bits, 2T) interval against four programmable limits. A spacing outside both windows is a timing error. So is a line that stays quiet longer than the long upper limit.

Reception runs through three phases. In the first, a run of valid short intervals (the preburst) must be seen; its length comes from a two-bit code. In the second, the block waits for a long interval, which serves as the start bit. In the third, each data-carrying transition yields a data bit on `dout` and a strobe on `dclk`. The strobe follows the transition after a fixed delay and lasts a fixed number of cycles. A timing error, or a long interval where the code allows none, stops the strobe at once and sends the block back to the first phase. A later preburst and start bit restart it without outside help. The first phase can be skipped, either by code value or by an external force input. A mode input switches from Manchester decoding to bi-phase decoding, where the strobe falls at the end of each bit.

Top module: `mdcr_top`

## Requirements
- R1: The line passes through a two-stage synchronizer. The spacing between two transitions, in clock cycles, is short when it lies in [t_lo, t_hi] and long when it lies in [t2_lo, t2_hi]; short wins if the windows overlap.
- R2: A spacing in neither window is a timing error. So is a line with no transition for t2_hi+1 cycles; this is flagged once, and the next transition then also counts as out of window.
- R3: rx_state encodes the phase as 0 = bit check, 1 = start search, 2 = clock active, and resets to 0. chk_sel values 0/1/2/3 mean 0/3/6/9 check bits. The check passes after 2x(bits) consecutive short intervals. A long interval or a timing error during the check sets its count back to zero.
- R4: When chk_sel is 0 or force_rx is 1, the bit-check phase is left for start search on the next clock. Errors then return the block to start search, not to bit check.
- R5: No strobe is given outside the clock-active phase. In start search, a long interval enters the clock-active phase, and the transition that ends it produces the first strobe.
- R6: A strobe rises at the (DELAY+2)-th rising clock edge after the edge that first samples the new line level. It stays high PULSE_W cycles, and dout takes the new bit at the same edge.
- R7: Manchester mode (biphase=0): after a strobed transition, a short interval then another short interval, or a single long interval, leads to the next strobed transition. dout is the line level after the strobed transition.
- R8: A long interval that follows an unstrobed transition is a code violation, handled as an error.
- R9: On an error in the clock-active phase, dclk is low from the next cycle, pending strobes are dropped, and the phase returns to bit check.
- R10: Bi-phase mode (biphase=1): strobes fall on bit boundaries. The start-bit strobe carries 0, two short intervals give a 1, and one long interval gives a 0.
- R11: err_sticky is set by any error in the clock-active phase and cleared by err_clr when no such error occurs in the same cycle. Errors in the other phases leave it unchanged.
- R12: After an error, a new bit check and start bit bring the strobes back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 1 | Demodulated serial line |
| t_lo | input | CNT_W | Short interval lower limit (cycles) |
| t_hi | input | CNT_W | Short interval upper limit (cycles) |
| t2_lo | input | CNT_W | Long interval lower limit (cycles) |
| t2_hi | input | CNT_W | Long interval upper limit and quiet timeout (cycles) |
| chk_sel | input | 2 | Bit-check length code: 0, 3, 6 or 9 bits |
| biphase | input | 1 | 1 = bi-phase decoding, 0 = Manchester |
| force_rx | input | 1 | Skip the bit-check phase |
| err_clr | input | 1 | Clear the sticky error flag |
| dout | output | 1 | Recovered data bit |
| dclk | output | 1 | Data-clock strobe |
| rx_state | output | 2 | Phase: 0 check, 1 search, 2 active |
| err_sticky | output | 1 | Error seen while the clock was active |

## Verification
The bench drives the line as level segments whose lengths are whole cycles. It compares every output each cycle against a behavioural model. Manchester words with runs of equal and alternating bits exercise both the short-short and the long route to a strobed transition. The same bits sent in bi-phase show that the data comes from the interval pattern and not from the line level. Spacings of 3 and 12 cycles, a quiet line, and a long interval after an unstrobed transition each separate one error path from the others. Broken and complete preburst runs, together with the skip controls, separate the check-counter reset from the threshold and from the bypass.

// File: rtl/mdcr_pkg.sv
package mdcr_pkg;
   typedef enum logic [1:0] {
      ST_CHECK  = 2'd0,
      ST_SEARCH = 2'd1,
      ST_ACTIVE = 2'd2
   } rx_state_e;

   typedef enum logic [1:0] {
      IV_NONE  = 2'd0,
      IV_SHORT = 2'd1,
      IV_LONG  = 2'd2,
      IV_BAD   = 2'd3
   } ival_e;
endpackage

// File: rtl/mdcr_sync_edge.sv
module mdcr_sync_edge #(
   parameter int STAGES = 2
)(
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic lvl,
   output logic tgl
);
   if (STAGES < 2) begin : g_bad_stages
      $error("mdcr_sync_edge: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;
   logic              lvl_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
         lvl_d <= 1'b0;
      end else begin
         chain <= {chain[STAGES-2:0], din};
         lvl_d <= chain[STAGES-1];
      end
   end

   assign lvl = chain[STAGES-1];
   assign tgl = lvl ^ lvl_d;

   // R1: a reported transition means the synchronized level moved since last cycle
   p_tgl_moves_r1: assert property (@(posedge clk) disable iff (!rst_n)
      tgl |-> (lvl != $past(lvl)));
endmodule

// File: rtl/mdcr_interval.sv
module mdcr_interval import mdcr_pkg::*; #(
   parameter int CNT_W = 8
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tgl,
   input  logic [CNT_W-1:0] t_lo,
   input  logic [CNT_W-1:0] t_hi,
   input  logic [CNT_W-1:0] t2_lo,
   input  logic [CNT_W-1:0] t2_hi,
   output ival_e            kind
);
   if (CNT_W < 4) begin : g_bad_cnt
      $error("mdcr_interval: CNT_W must be at least 4");
   end

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] run;
   logic [CNT_W:0]   len;
   logic             in_short, in_long;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              run <= '0;
      else if (tgl)            run <= '0;
      else if (run != CNT_MAX) run <= run + 1'b1;
   end

   assign len      = {1'b0, run} + 1'b1;
   assign in_short = (len >= {1'b0, t_lo})  && (len <= {1'b0, t_hi});
   assign in_long  = (len >= {1'b0, t2_lo}) && (len <= {1'b0, t2_hi});

   always_comb begin
      if (tgl) begin
         if (in_short)     kind = IV_SHORT;
         else if (in_long) kind = IV_LONG;
         else              kind = IV_BAD;
      end else if (run == t2_hi) begin
         kind = IV_BAD;
      end else begin
         kind = IV_NONE;
      end
   end

   // R1: measurement restarts on each transition
   p_run_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
      tgl |=> (run == '0));
   // R2: a quiet line holds the counter at its ceiling
   p_run_sat_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (run == CNT_MAX && !tgl) |=> (run == CNT_MAX));
endmodule

// File: rtl/mdcr_ctrl.sv
module mdcr_ctrl import mdcr_pkg::*; (
   input  logic      clk,
   input  logic      rst_n,
   input  ival_e     kind,
   input  logic      lvl,
   input  logic [1:0] chk_sel,
   input  logic      biphase,
   input  logic      force_rx,
   output rx_state_e state,
   output logic      fire,
   output logic      fire_data,
   output logic      kill
);
   localparam int BITS_PER_CODE = 3;
   localparam int HALVES        = 2;
   localparam int MAX_SHORTS    = HALVES * BITS_PER_CODE * 3;
   localparam int CHK_W         = $clog2(MAX_SHORTS + 1);

   logic [CHK_W-1:0] chk, chk_n, chk_need;
   logic             phase, phase_n, skip;
   rx_state_e        state_n, home;

   assign skip     = force_rx || (chk_sel == 2'd0);
   assign home     = skip ? ST_SEARCH : ST_CHECK;
   assign chk_need = CHK_W'(chk_sel) * CHK_W'(HALVES * BITS_PER_CODE);

   always_comb begin
      state_n   = state;
      chk_n     = chk;
      phase_n   = phase;
      fire      = 1'b0;
      fire_data = 1'b0;
      kill      = 1'b0;
      case (state)
         ST_CHECK: begin
            if (skip) begin
               state_n = ST_SEARCH;
               chk_n   = '0;
            end else if (kind == IV_SHORT) begin
               if ((chk + 1'b1) >= chk_need) begin
                  state_n = ST_SEARCH;
                  chk_n   = '0;
               end else begin
                  chk_n = chk + 1'b1;
               end
            end else if (kind != IV_NONE) begin
               chk_n = '0;
            end
         end
         ST_SEARCH: begin
            if (kind == IV_BAD) begin
               state_n = home;
               chk_n   = '0;
            end else if (kind == IV_LONG) begin
               state_n   = ST_ACTIVE;
               phase_n   = 1'b1;
               fire      = 1'b1;
               fire_data = biphase ? 1'b0 : lvl;
            end
         end
         ST_ACTIVE: begin
            if (kind == IV_BAD || (kind == IV_LONG && !phase)) begin
               state_n = home;
               chk_n   = '0;
               kill    = 1'b1;
            end else if (kind == IV_SHORT) begin
               phase_n = !phase;
               if (!phase) begin
                  fire      = 1'b1;
                  fire_data = biphase ? 1'b1 : lvl;
               end
            end else if (kind == IV_LONG) begin
               fire      = 1'b1;
               fire_data = biphase ? 1'b0 : lvl;
            end
         end
         default: begin
            state_n = ST_CHECK;
            chk_n   = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_CHECK;
         chk   <= '0;
         phase <= 1'b0;
      end else begin
         state <= state_n;
         chk   <= chk_n;
         phase <= phase_n;
      end
   end

   // R5: a start bit found during search opens the clock-active phase
   p_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SEARCH && kind == IV_LONG) |=> (state == ST_ACTIVE));
   // R9: a timing error ends the clock-active phase
   p_leave_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ACTIVE && kind == IV_BAD) |=> (state != ST_ACTIVE));
   // R8: long interval after an unstrobed transition ends the phase
   p_violation_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ACTIVE && kind == IV_LONG && !phase) |=> (state != ST_ACTIVE));
   // R4: bypass leaves bit check at once
   p_skip_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_CHECK && skip) |=> (state == ST_SEARCH));
endmodule

// File: rtl/mdcr_pulse.sv
module mdcr_pulse #(
   parameter int DELAY   = 2,
   parameter int PULSE_W = 3
)(
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   input  logic fire_data,
   input  logic kill,
   output logic dclk,
   output logic dout
);
   if (PULSE_W < 1) begin : g_bad_pw
      $error("mdcr_pulse: PULSE_W must be at least 1");
   end
   if (DELAY < 0) begin : g_bad_dly
      $error("mdcr_pulse: DELAY must not be negative");
   end

   localparam int PW_W = $clog2(PULSE_W + 1);

   logic            d_fire, d_data;
   logic [PW_W-1:0] pw;
   logic            data_q;

   if (DELAY == 0) begin : g_direct
      assign d_fire = fire;
      assign d_data = fire_data;
   end else begin : g_pipe
      logic [DELAY-1:0] pf, pd;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pf <= '0;
            pd <= '0;
         end else if (kill) begin
            pf <= '0;
            pd <= '0;
         end else begin
            pf <= (pf << 1) | DELAY'(fire);
            pd <= (pd << 1) | DELAY'(fire_data);
         end
      end
      assign d_fire = pf[DELAY-1];
      assign d_data = pd[DELAY-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pw     <= '0;
         data_q <= 1'b0;
      end else if (kill) begin
         pw <= '0;
      end else if (d_fire) begin
         pw     <= PW_W'(PULSE_W);
         data_q <= d_data;
      end else if (pw != '0) begin
         pw <= pw - 1'b1;
      end
   end

   assign dclk = (pw != '0);
   assign dout = data_q;

   // R9: the strobe stops on the cycle after an error
   p_kill_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      kill |=> !dclk);
   // R6: a matured strobe request raises the strobe
   p_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (d_fire && !kill) |=> dclk);
endmodule

// File: rtl/mdcr_top.sv
module mdcr_top import mdcr_pkg::*; #(
   parameter int CNT_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter int DELAY       = 2,
   parameter int PULSE_W     = 3
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             din,
   input  logic [CNT_W-1:0] t_lo,
   input  logic [CNT_W-1:0] t_hi,
   input  logic [CNT_W-1:0] t2_lo,
   input  logic [CNT_W-1:0] t2_hi,
   input  logic [1:0]       chk_sel,
   input  logic             biphase,
   input  logic             force_rx,
   input  logic             err_clr,
   output logic             dout,
   output logic             dclk,
   output logic [1:0]       rx_state,
   output logic             err_sticky
);
   logic      lvl, tgl, fire, fire_data, kill;
   ival_e     kind;
   rx_state_e state;

   mdcr_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(din), .lvl(lvl), .tgl(tgl));

   mdcr_interval #(.CNT_W(CNT_W)) u_ival (
      .clk(clk), .rst_n(rst_n), .tgl(tgl),
      .t_lo(t_lo), .t_hi(t_hi), .t2_lo(t2_lo), .t2_hi(t2_hi), .kind(kind));

   mdcr_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .kind(kind), .lvl(lvl), .chk_sel(chk_sel),
      .biphase(biphase), .force_rx(force_rx), .state(state),
      .fire(fire), .fire_data(fire_data), .kill(kill));

   mdcr_pulse #(.DELAY(DELAY), .PULSE_W(PULSE_W)) u_pulse (
      .clk(clk), .rst_n(rst_n), .fire(fire), .fire_data(fire_data),
      .kill(kill), .dclk(dclk), .dout(dout));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       err_sticky <= 1'b0;
      else if (kill)    err_sticky <= 1'b1;
      else if (err_clr) err_sticky <= 1'b0;
   end

   assign rx_state = state;

   // R5: no strobe outside the clock-active phase
   p_quiet_outside_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_ACTIVE) |-> !dclk);
   // R11: the flag holds until cleared
   p_sticky_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (err_sticky && !err_clr) |=> err_sticky);
endmodule

// File: tb/tb_mdcr_top.sv
`timescale 1ns/1ps
module tb_mdcr_top;
   localparam int CNT_W = 8, DELAY = 2, PULSE_W = 3;
   localparam int TLO = 6, THI = 10, T2LO = 14, T2HI = 18;

   logic clk = 1'b0, rst_n = 1'b0, din = 1'b0;
   logic [1:0] chk_sel = 2'd1;
   logic biphase = 1'b0, force_rx = 1'b0, err_clr = 1'b0;
   logic dout, dclk, err_sticky;
   logic [1:0] rx_state;

   always #2.5 clk = ~clk;

   mdcr_top #(.CNT_W(CNT_W), .SYNC_STAGES(2), .DELAY(DELAY), .PULSE_W(PULSE_W)) dut (
      .clk(clk), .rst_n(rst_n), .din(din),
      .t_lo(8'(TLO)), .t_hi(8'(THI)), .t2_lo(8'(T2LO)), .t2_hi(8'(T2HI)),
      .chk_sel(chk_sel), .biphase(biphase), .force_rx(force_rx), .err_clr(err_clr),
      .dout(dout), .dclk(dclk), .rx_state(rx_state), .err_sticky(err_sticky));

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int m_q1, m_q2, m_q3, m_cnt, m_st, m_chk, m_p, m_pw, m_dq, m_stk, m_cyc;
   int due_q[$], dat_q[$];
   int len, need, nst, nchk, np, fd;
   bit e, sh, lg, er, skip, fire, kill, dfire;
   int dd;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_q1 = 0; m_q2 = 0; m_q3 = 0; m_cnt = 0; m_st = 0; m_chk = 0; m_p = 0;
         m_pw = 0; m_dq = 0; m_stk = 0; m_cyc = 0;
         due_q.delete(); dat_q.delete();
      end else begin
         e    = (m_q2 != m_q3);
         len  = m_cnt + 1;
         sh   = e && len >= TLO && len <= THI;
         lg   = e && !sh && len >= T2LO && len <= T2HI;
         er   = (e && !sh && !lg) || (!e && m_cnt == T2HI);
         skip = force_rx || chk_sel == 0;
         need = 6 * int'(chk_sel);
         nst = m_st; nchk = m_chk; np = m_p; fire = 0; fd = 0; kill = 0;
         if (m_st == 0) begin
            if (skip) begin nst = 1; nchk = 0; end
            else if (sh) begin
               if (m_chk + 1 >= need) begin nst = 1; nchk = 0; end
               else nchk = m_chk + 1;
            end else if (er || lg) nchk = 0;
         end else if (m_st == 1) begin
            if (er) begin nst = skip ? 1 : 0; nchk = 0; end
            else if (lg) begin nst = 2; np = 1; fire = 1; fd = biphase ? 0 : m_q2; end
         end else begin
            if (er || (lg && m_p == 0)) begin nst = skip ? 1 : 0; nchk = 0; kill = 1; end
            else if (sh) begin
               np = 1 - m_p;
               if (m_p == 0) begin fire = 1; fd = biphase ? 1 : m_q2; end
            end else if (lg) begin fire = 1; fd = biphase ? 0 : m_q2; end
         end
         if (fire) begin due_q.push_back(m_cyc + DELAY); dat_q.push_back(fd); end
         dfire = 0; dd = 0;
         if (due_q.size() > 0 && due_q[0] == m_cyc) begin
            dfire = 1; dd = dat_q[0];
            void'(due_q.pop_front()); void'(dat_q.pop_front());
         end
         if (kill) begin due_q.delete(); dat_q.delete(); m_pw = 0; end
         else if (dfire) begin m_pw = PULSE_W; m_dq = dd; end
         else if (m_pw > 0) m_pw--;
         if (kill) m_stk = 1; else if (err_clr) m_stk = 0;
         if (e) m_cnt = 0; else if (m_cnt != 255) m_cnt++;
         m_st = nst; m_chk = nchk; m_p = np;
         m_q3 = m_q2; m_q2 = m_q1; m_q1 = int'(din);
         m_cyc++;
      end
   end

   // ---------------- monitor and per-cycle compare ----------------
   int pcnt = 0;
   always @(posedge clk) pcnt++;

   int got[$], exp_bits[$];
   bit dclk_prev = 0, arm_rise = 0;
   int rise_pc = 0, pw_len = 0, last_w = 0, pulses = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         check("R6 dclk per cycle", int'(dclk), int'(m_pw != 0));
         check("R7 dout per cycle", int'(dout), m_dq);
         check("R3 rx_state per cycle", int'(rx_state), m_st);
         check("R11 err_sticky per cycle", int'(err_sticky), m_stk);
         if (dclk && !dclk_prev) begin
            got.push_back(int'(dout));
            pulses++;
            pw_len = 1;
            if (arm_rise) begin rise_pc = pcnt; arm_rise = 0; end
         end else if (dclk) pw_len++;
         else if (dclk_prev) last_w = pw_len;
         dclk_prev = dclk;
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic hold(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic preburst(input int n);
      for (int i = 0; i < n; i++) begin din = !din; hold(8); end
   endtask

   task automatic start_bit();   // line held 8 already; 8 more then transition
      hold(8);
      din = !din;
      exp_bits.push_back(biphase ? 0 : int'(din));
   endtask

   task automatic man_bit(input int b);
      if (int'(din) == b) begin hold(8); din = !din; hold(8); end
      else hold(16);
      din = b[0];
      exp_bits.push_back(b);
   endtask

   task automatic bp_bit(input int b);
      if (b == 1) begin hold(8); din = !din; hold(8); end
      else hold(16);
      din = !din;
      exp_bits.push_back(b);
   endtask

   task automatic compare_bits(input string tag);
      check({tag, " count"}, got.size(), exp_bits.size());
      for (int i = 0; i < exp_bits.size() && i < got.size(); i++)
         check({tag, " bit"}, got[i], exp_bits[i]);
      got.delete(); exp_bits.delete();
   endtask

   task automatic clear_flag();
      err_clr = 1'b1; hold(1); err_clr = 1'b0; hold(1);
   endtask

   int tog_pc, p0;

   initial begin
      hold(3);
      rst_n = 1'b1;
      hold(1);
      check("R3 reset phase", int'(rx_state), 0);
      check("R5 reset strobe", int'(dclk), 0);
      check("R11 reset flag", int'(err_sticky), 0);

      // S1: Manchester word after a 3-bit check
      hold(25);
      got.delete(); exp_bits.delete();
      preburst(10);
      check("R1 short intervals pass the check", int'(rx_state), 1);
      hold(8);
      din = !din; tog_pc = pcnt; arm_rise = 1;
      exp_bits.push_back(int'(din));
      man_bit(1); man_bit(1); man_bit(0); man_bit(0); man_bit(1); man_bit(0);
      hold(8);
      check("R5 start bit enters active", int'(rx_state), 2);
      check("R6 strobe latency", rise_pc - tog_pc, DELAY + 3);
      check("R6 strobe width", last_w, PULSE_W);
      compare_bits("R7 manchester data");
      hold(30);
      check("R2 quiet line ends reception", int'(rx_state), 0);
      check("R11 flag set by active error", int'(err_sticky), 1);
      clear_flag();
      check("R11 flag cleared", int'(err_sticky), 0);

      // S2: too-short spacing while active
      preburst(10); start_bit(); man_bit(0); man_bit(1);
      hold(3); din = !din;
      hold(3);
      check("R9 short error stops clock", int'(dclk), 0);
      check("R9 short error returns to check", int'(rx_state), 0);
      check("R11 flag after short error", int'(err_sticky), 1);
      hold(30);
      got.delete(); exp_bits.delete();

      // S3: spacing between windows, then resume
      p0 = pulses;
      preburst(10); start_bit(); man_bit(1);
      hold(12); din = !din;
      hold(3);
      check("R2 spacing between windows is an error", int'(rx_state), 0);
      hold(30);
      p0 = pulses;
      got.delete(); exp_bits.delete();
      preburst(10); start_bit(); man_bit(0); man_bit(0);
      hold(8);
      check("R12 strobes resume", pulses - p0, 3);
      compare_bits("R12 resumed data");
      hold(30);

      // S4: code violation
      preburst(10); start_bit();
      hold(8); din = !din; hold(16); din = !din;
      hold(3);
      check("R8 long after unstrobed transition", int'(rx_state), 0);
      hold(30);
      got.delete(); exp_bits.delete();

      // S5: check counter reset with 6-bit check
      chk_sel = 2'd2;
      hold(30);
      preburst(8);
      hold(8); din = !din; hold(8);
      preburst(8);
      check("R3 long interval restarts the check", int'(rx_state), 0);
      preburst(6);
      check("R3 six-bit check completes", int'(rx_state), 1);
      hold(30);

      // S6: bypass controls
      chk_sel = 2'd3; force_rx = 1'b1;
      hold(2);
      check("R4 force skips the check", int'(rx_state), 1);
      force_rx = 1'b0; chk_sel = 2'd0;
      hold(30);
      check("R4 zero-length check returns to search", int'(rx_state), 1);

      // S7: bi-phase word
      biphase = 1'b1;
      got.delete(); exp_bits.delete();
      preburst(4); start_bit();
      bp_bit(1); bp_bit(0); bp_bit(1); bp_bit(1); bp_bit(0);
      hold(8);
      compare_bits("R10 biphase data");
      hold(30);
      check("R10 quiet line ends biphase reception", int'(rx_state), 1);
      hold(4);
      finish_run();
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         finish_run();
      end
   end
endmodule